// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a carry input and returns their sum together with a carry output. It is meant for datapaths where carry delay sets the cycle time. The operand is cut into equal slices of four bits by default. Each slice forms per-bit generate (both operand bits set) and propagate (operand bits differ) terms, and it derives every internal carry in flat sum-of-products form from those terms and the slice carry input. Each slice also reports a group generate and a group propagate to a shared second-level lookahead unit.

The second-level unit works from the group terms and the block carry input. It produces the carry into every slice, and the final carry output, in the same flat form, so no carry travels serially from slice to slice. With the default 16-bit width this gives a carry depth of roughly eight gate levels. A ripple chain of the same width needs roughly thirty-two. The width and slice width are parameters, and illegal combinations are rejected at elaboration.

Top module: `hcla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, for any operand values.
- R2: `carry_out` equals bit WIDTH of `op_a + op_b + carry_in`, which is the unsigned overflow of the addition.
- R3: An operand of all ones plus one, with `carry_in` = 0, gives `sum` = 0 and `carry_out` = 1. The carry crosses every slice.
- R4: With `carry_in` = 1, an all-ones operand plus zero gives `sum` = 0 and `carry_out` = 1, and zero plus zero gives `sum` = 1 and `carry_out` = 0.
- R5: A carry generated in the top bit of one slice (bit 3, 7 or 11 at default width) arrives at the lowest bit of the next slice. For example, 0x000F + 0x0001 gives 0x0010, and 0x0F00 + 0x0100 gives 0x1000.
- R6: Each slice's group generate and group propagate are never both 1. The slice's own carry out of its top bit equals group generate OR (group propagate AND slice carry input).
- R7: The second-level unit's carry into slice k+1 equals the group generate of slice k OR (the group propagate of slice k AND the carry into slice k). The carry into slice 0 is `carry_in`.
- R8: Zero plus zero with `carry_in` = 0 gives `sum` = 0 and `carry_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH (16) | First addend |
| op_b | input | WIDTH (16) | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH (16) | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The block holds no state, so every internal fault shows at the ports in the same evaluation in which the bad operands are applied. A wrong group generate or propagate term, or a wrong second-level carry, flips every sum bit from the first bit of the affected slice up to the point where the true carry chain would have been cut. A wrong per-bit term or a wrong intra-slice carry corrupts only the bits above it within that slice, unless it changes the slice's carry out. The directed cases therefore force long carry chains across one, several and all slice boundaries, in addition to random operands.

// File: rtl/hcla_pkg.sv
package hcla_pkg;

   localparam int unsigned LA_MAX = 32;

   // Flat lookahead carry into position k from generate/propagate vectors
   // and the carry entering position 0: OR of every generate term masked by
   // all propagates above it, plus the fully propagated input carry.
   function automatic logic la_carry(input logic [LA_MAX-1:0] gen,
                                     input logic [LA_MAX-1:0] prop,
                                     input logic              c0,
                                     input int unsigned       k);
      logic any;
      logic term;
      any  = c0;
      for (int unsigned j = 0; j < k; j++) any = any & prop[j];
      for (int unsigned j = 0; j < k; j++) begin
         term = gen[j];
         for (int unsigned m = j + 1; m < k; m++) term = term & prop[m];
         any = any | term;
      end
      return any;
   endfunction

endpackage

// File: rtl/hcla_pg_cell.sv
module hcla_pg_cell (
   input  logic bit_a,
   input  logic bit_b,
   output logic bit_gen,
   output logic bit_prop
);
   assign bit_gen  = bit_a & bit_b;
   assign bit_prop = bit_a ^ bit_b;
endmodule

// File: rtl/hcla_slice.sv
module hcla_slice #(
   parameter int unsigned SW = 4
) (
   input  logic [SW-1:0] sa,
   input  logic [SW-1:0] sb,
   input  logic          scin,
   output logic [SW-1:0] ssum,
   output logic          grp_gen,
   output logic          grp_prop
);
   import hcla_pkg::*;

   localparam int unsigned PADW = LA_MAX - SW;

   if (SW < 1 || SW > LA_MAX) begin : g_bad_sw
      $error("hcla_slice: SW out of range");
   end

   logic [SW-1:0] g_bits;
   logic [SW-1:0] p_bits;
   logic [SW:0]   cvec;

   for (genvar i = 0; i < int'(SW); i++) begin : g_cell
      hcla_pg_cell u_cell (
         .bit_a   (sa[i]),
         .bit_b   (sb[i]),
         .bit_gen (g_bits[i]),
         .bit_prop(p_bits[i])
      );
   end

   logic [LA_MAX-1:0] g_ext;
   logic [LA_MAX-1:0] p_ext;
   assign g_ext = {{PADW{1'b0}}, g_bits};
   assign p_ext = {{PADW{1'b0}}, p_bits};

   always_comb begin
      cvec[0] = scin;
      for (int unsigned k = 1; k <= SW; k++) cvec[k] = la_carry(g_ext, p_ext, scin, k);
      grp_prop = &p_bits;
      grp_gen  = la_carry(g_ext, p_ext, 1'b0, SW);
      ssum     = p_bits ^ cvec[SW-1:0];
   end

   always_comb begin
      // R6
      grp_excl_chk: assert (!(grp_gen && grp_prop))
         else $error("slice group generate and propagate both set");
      // R6
      slice_cout_chk: assert (cvec[SW] == (grp_gen | (grp_prop & scin)))
         else $error("slice carry out disagrees with group terms");
      // R1
      slice_sum_chk: assert ({cvec[SW], ssum} ==
                             ({1'b0, sa} + {1'b0, sb} + {{SW{1'b0}}, scin}))
         else $error("slice sum mismatch");
   end

endmodule

// File: rtl/hcla_group_unit.sv
module hcla_group_unit #(
   parameter int unsigned NG = 4
) (
   input  logic [NG-1:0] gg,
   input  logic [NG-1:0] gp,
   input  logic          c0,
   output logic [NG-1:0] slice_cin,
   output logic          final_cout
);
   import hcla_pkg::*;

   localparam int unsigned PADG = LA_MAX - NG;

   if (NG < 1 || NG > LA_MAX) begin : g_bad_ng
      $error("hcla_group_unit: NG out of range");
   end

   logic [LA_MAX-1:0] gg_ext;
   logic [LA_MAX-1:0] gp_ext;
   logic [NG:0]       cg;

   assign gg_ext = {{PADG{1'b0}}, gg};
   assign gp_ext = {{PADG{1'b0}}, gp};

   always_comb begin
      for (int unsigned k = 0; k <= NG; k++) cg[k] = la_carry(gg_ext, gp_ext, c0, k);
   end

   assign slice_cin  = cg[NG-1:0];
   assign final_cout = cg[NG];

   always_comb begin
      // R7
      grp_base_chk: assert (cg[0] == c0)
         else $error("carry into slice 0 differs from carry_in");
      for (int unsigned k = 0; k < NG; k++) begin
         // R7
         grp_step_chk: assert (cg[k+1] == (gg[k] | (gp[k] & cg[k])))
            else $error("group carry %0d breaks recurrence", k + 1);
      end
   end

endmodule

// File: rtl/hcla_adder.sv
module hcla_adder #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned SLICE_W = 4
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   localparam int unsigned NSLICE = WIDTH / SLICE_W;

   if (SLICE_W == 0 || WIDTH % SLICE_W != 0) begin : g_bad_split
      $error("hcla_adder: WIDTH must be a multiple of SLICE_W");
   end
   if (NSLICE > 32 || SLICE_W > 32) begin : g_bad_size
      $error("hcla_adder: too many slices or slice too wide");
   end

   logic [NSLICE-1:0] s_gen;
   logic [NSLICE-1:0] s_prop;
   logic [NSLICE-1:0] s_cin;

   for (genvar s = 0; s < int'(NSLICE); s++) begin : g_slice
      hcla_slice #(.SW(SLICE_W)) u_slice (
         .sa      (op_a[s*SLICE_W +: SLICE_W]),
         .sb      (op_b[s*SLICE_W +: SLICE_W]),
         .scin    (s_cin[s]),
         .ssum    (sum[s*SLICE_W +: SLICE_W]),
         .grp_gen (s_gen[s]),
         .grp_prop(s_prop[s])
      );
   end

   hcla_group_unit #(.NG(NSLICE)) u_group (
      .gg        (s_gen),
      .gp        (s_prop),
      .c0        (carry_in),
      .slice_cin (s_cin),
      .final_cout(carry_out)
   );

endmodule

// File: tb/hcla_adder_bench.sv
module hcla_adder_bench;
   localparam int unsigned W = 16;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum;
   logic         carry_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hcla_adder #(.WIDTH(W), .SLICE_W(4)) u_hcla_adder (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .sum(sum), .carry_out(carry_out)
   );

   task automatic apply_and_check(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic ci, input string req);
      logic [W:0] expv;
      @(posedge clk);
      op_a = a; op_b = b; carry_in = ci;
      @(negedge clk);
      expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      total++;
      if ({carry_out, sum} !== expv) begin
         bad++;
         $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h",
                  req, a, b, ci, {carry_out, sum}, expv);
      end
   endtask

   task automatic t_reset_zero();   // R8
      apply_and_check('0, '0, 1'b0, "R8");
   endtask

   task automatic t_full_chain();   // R3
      apply_and_check('1, 16'h0001, 1'b0, "R3");
      apply_and_check(16'h0001, '1, 1'b0, "R3");
   endtask

   task automatic t_carry_in();     // R4
      apply_and_check('1, '0, 1'b1, "R4");
      apply_and_check('0, '0, 1'b1, "R4");
      apply_and_check('1, '1, 1'b1, "R4");
   endtask

   task automatic t_slice_edges();  // R5, R6, R7
      apply_and_check(16'h000F, 16'h0001, 1'b0, "R5");
      apply_and_check(16'h00F0, 16'h0010, 1'b0, "R5");
      apply_and_check(16'h0F00, 16'h0100, 1'b0, "R5");
      apply_and_check(16'h0FFF, 16'h0000, 1'b1, "R7");
      apply_and_check(16'h8888, 16'h8888, 1'b0, "R6");
      apply_and_check(16'h5555, 16'hAAAA, 1'b1, "R6");
      apply_and_check(16'h00FF, 16'h0F01, 1'b0, "R7");
   endtask

   task automatic t_overflow();     // R2
      apply_and_check(16'h8000, 16'h8000, 1'b0, "R2");
      apply_and_check(16'hFFFE, 16'h0001, 1'b0, "R2");
      apply_and_check(16'hC000, 16'h4000, 1'b1, "R2");
   endtask

   task automatic t_random();       // R1
      for (int n = 0; n < 400; n++) begin
         apply_and_check(W'($urandom), W'($urandom), 1'($urandom), "R1");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_zero();
      t_full_chain();
      t_carry_in();
      t_slice_edges();
      t_overflow();
      t_random();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule